// File: doc/BRIEF.md
# Integer Instruction Execute Unit

A purely combinational decode-and-execute slice for a 32-bit load/store RISC integer subset. Each evaluation takes one instruction word and the two source operand values already read from the register file. It returns the destination register index, a write strobe, the computed value, a signed-overflow exception flag and an illegal-instruction flag. The surrounding pipeline owns the register file, the exception response and all memory, branch and multiply/divide work.

Register-register operations, register-immediate operations, constant and variable shifts, and the load-upper form are executed. The trapping and wrapping add/subtract forms use the same adder. The set-less-than compares also use it. Immediates are sign- or zero-extended according to the opcode.

Fields: `op = instr[31:26]`, `rs = instr[25:21]`, `rt = instr[20:16]`, `rd = instr[15:11]`, `sh = instr[10:6]`, `fn = instr[5:0]`, `imm = instr[15:0]`. Below, `A` is `rs_val_i`, `B` is `rt_val_i`, `SE` is `imm` sign-extended to 32 bits, and `ZE` is `imm` zero-extended to 32 bits.

Top module: `risc_exec_unit`

## Requirements
- R1: When `op` is 0, the destination index is `rd`. For every other legal opcode, the destination index is `rt`.
- R2: Wrapping arithmetic computes modulo 2^32. Function 0x21 gives A+B and function 0x23 gives A-B. Opcode 9 gives A+SE. None of these raises the overflow flag, and each writes its result.
- R3: The trapping forms are function 0x20 (A+B), function 0x22 (A-B) and opcode 8 (A+SE). On signed overflow they raise `ovf_o` and hold `wr_en_o` low. Otherwise they behave like the wrapping forms.
- R4: Bitwise operations on registers are function 0x24 A&B, 0x25 A|B, 0x26 A^B and 0x27 ~(A|B).
- R5: Compares write 1 or 0. Function 0x2A is signed A<B and opcode 10 is signed A<SE. Function 0x2B is unsigned A<B and opcode 11 is unsigned A<SE, where SE is sign-extended first.
- R6: Opcodes 12, 13 and 14 give A&ZE, A|ZE and A^ZE. For example, opcode 13 with A=0 and imm=0xFFFF gives 0x0000FFFF.
- R7: Constant shifts move B by `sh`. Function 0x00 shifts left, 0x02 shifts right logically with zero fill, and 0x03 shifts right arithmetically with B[31] fill.
- R8: Variable shifts move A by B[4:0], and bits B[31:5] have no effect. Function 0x04 shifts left, 0x06 shifts right with zero fill, and 0x07 shifts right with A[31] fill.
- R9: Opcode 15 yields {imm, 16'h0}.
- R10: A destination index of 0 always holds `wr_en_o` low. The all-zero word therefore has no effect.
- R11: Any opcode other than 0 and 8..15, and any function value not listed above when `op` is 0, raises `illegal_o` and holds `wr_en_o` and `ovf_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | DATA_W | Value of the first source register |
| rt_val_i | input | DATA_W | Value of the second source register |
| dst_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write strobe |
| result_o | output | DATA_W | Computed value |
| ovf_o | output | 1 | Signed-overflow exception from a trapping form |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
The unit holds no state, so a decode or datapath fault shows up at the ports in the same evaluation as the instruction that triggers it. A wrong decode shows up in one of three ways:
- a result computed by the wrong operation;
- an index taken from the wrong field;
- a write strobe that stays high across an overflow or a zero destination.

Each of these is compared for every vector against an independent reference function. Operand values are biased toward the sign boundaries, where overflow, signed-compare and arithmetic-fill faults appear.

// File: rtl/risc_exec_pkg.sv
package risc_exec_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int IMM_W     = 16;
  localparam int OPC_W     = 6;
  localparam int FN_W      = 6;
  localparam int SA_W      = 5;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_imm;
    logic    imm_sext;
    logic    var_shift;
    logic    dst_rd;
    logic    traps;
    logic    legal;
  } exec_ctrl_t;
endpackage

// File: rtl/risc_exec_decode.sv
module risc_exec_decode
  import risc_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output exec_ctrl_t       ctrl_o
);
  exec_ctrl_t c;

  always_comb begin
    c          = '0;
    c.op       = ALU_ADD;
    c.legal    = 1'b1;
    if (opc_i == OPC_REG) begin
      c.dst_rd = 1'b1;
      unique case (fn_i)
        FN_ADD:  begin c.op = ALU_ADD; c.traps = 1'b1; end
        FN_ADDU: c.op = ALU_ADD;
        FN_SUB:  begin c.op = ALU_SUB; c.traps = 1'b1; end
        FN_SUBU: c.op = ALU_SUB;
        FN_AND:  c.op = ALU_AND;
        FN_OR:   c.op = ALU_OR;
        FN_XOR:  c.op = ALU_XOR;
        FN_NOR:  c.op = ALU_NOR;
        FN_SLT:  c.op = ALU_SLT;
        FN_SLTU: c.op = ALU_SLTU;
        FN_SLL:  c.op = ALU_SLL;
        FN_SRL:  c.op = ALU_SRL;
        FN_SRA:  c.op = ALU_SRA;
        FN_SLLV: begin c.op = ALU_SLL; c.var_shift = 1'b1; end
        FN_SRLV: begin c.op = ALU_SRL; c.var_shift = 1'b1; end
        FN_SRAV: begin c.op = ALU_SRA; c.var_shift = 1'b1; end
        default: c.legal = 1'b0;
      endcase
    end else begin
      c.use_imm = 1'b1;
      unique case (opc_i)
        OPC_ADDI:  begin c.op = ALU_ADD;  c.imm_sext = 1'b1; c.traps = 1'b1; end
        OPC_ADDIU: begin c.op = ALU_ADD;  c.imm_sext = 1'b1; end
        OPC_SLTI:  begin c.op = ALU_SLT;  c.imm_sext = 1'b1; end
        OPC_SLTIU: begin c.op = ALU_SLTU; c.imm_sext = 1'b1; end
        OPC_ANDI:  c.op = ALU_AND;
        OPC_ORI:   c.op = ALU_OR;
        OPC_XORI:  c.op = ALU_XOR;
        OPC_LUI:   c.op = ALU_LUI;
        default:   c.legal = 1'b0;
      endcase
    end
  end

  assign ctrl_o = c;
endmodule

// File: rtl/risc_exec_alu.sv
module risc_exec_alu
  import risc_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  exec_ctrl_t        ctrl_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SA_W-1:0]   sa_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_raw_o
);
  localparam int MSB     = DATA_W - 1;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int EXT_W   = DATA_W - IMM_W;

  logic [DATA_W-1:0]  imm_ext, b_op, b_add, sh_src;
  logic [DATA_W:0]    sum_w;
  logic [SHAMT_W-1:0] amt;
  logic               sub_sel, lt_s, lt_u;

  assign imm_ext = ctrl_i.imm_sext ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i}
                                   : {{EXT_W{1'b0}}, imm_i};
  assign b_op    = ctrl_i.use_imm ? imm_ext : rt_val_i;

  // one adder: add, sub and both compares
  assign sub_sel   = (ctrl_i.op == ALU_SUB) || (ctrl_i.op == ALU_SLT) || (ctrl_i.op == ALU_SLTU);
  assign b_add     = sub_sel ? ~b_op : b_op;
  assign sum_w     = {1'b0, rs_val_i} + {1'b0, b_add} + (DATA_W+1)'(sub_sel);
  assign ovf_raw_o = (rs_val_i[MSB] == b_add[MSB]) && (sum_w[MSB] != rs_val_i[MSB]);
  assign lt_s      = sum_w[MSB] ^ ovf_raw_o;
  assign lt_u      = ~sum_w[DATA_W];

  assign sh_src = ctrl_i.var_shift ? rs_val_i : rt_val_i;
  assign amt    = ctrl_i.var_shift ? rt_val_i[SHAMT_W-1:0] : SHAMT_W'(sa_i);

  always_comb begin
    unique case (ctrl_i.op)
      ALU_ADD,
      ALU_SUB:  result_o = sum_w[MSB:0];
      ALU_AND:  result_o = rs_val_i & b_op;
      ALU_OR:   result_o = rs_val_i | b_op;
      ALU_XOR:  result_o = rs_val_i ^ b_op;
      ALU_NOR:  result_o = ~(rs_val_i | b_op);
      ALU_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
      ALU_SLTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
      ALU_SLL:  result_o = sh_src << amt;
      ALU_SRL:  result_o = sh_src >> amt;
      ALU_SRA:  result_o = DATA_W'($signed(sh_src) >>> amt);
      ALU_LUI:  result_o = {imm_i, {EXT_W{1'b0}}};
      default:  result_o = '0;
    endcase
  end
endmodule

// File: rtl/risc_exec_wb_gate.sv
module risc_exec_wb_gate
  import risc_exec_pkg::*;
(
  input  logic                 legal_i,
  input  logic                 traps_i,
  input  logic                 dst_rd_i,
  input  logic                 ovf_raw_i,
  input  logic [REG_IDX_W-1:0] rd_i,
  input  logic [REG_IDX_W-1:0] rt_i,
  output logic [REG_IDX_W-1:0] dst_idx_o,
  output logic                 wr_en_o,
  output logic                 ovf_o,
  output logic                 illegal_o
);
  assign dst_idx_o = dst_rd_i ? rd_i : rt_i;
  assign ovf_o     = legal_i & traps_i & ovf_raw_i;
  assign wr_en_o   = legal_i & ~ovf_o & (dst_idx_o != '0);
  assign illegal_o = ~legal_i;
endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
  import risc_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [DATA_W-1:0]    rs_val_i,
  input  logic [DATA_W-1:0]    rt_val_i,
  output logic [REG_IDX_W-1:0] dst_idx_o,
  output logic                 wr_en_o,
  output logic [DATA_W-1:0]    result_o,
  output logic                 ovf_o,
  output logic                 illegal_o
);
  exec_ctrl_t ctrl;
  logic       ovf_raw;
  logic [REG_IDX_W-1:0] unused_rs;

  assign unused_rs = instr_i[25:21]; // operand already fetched by the caller

  risc_exec_decode u_dec (
    .opc_i  (instr_i[31:26]),
    .fn_i   (instr_i[5:0]),
    .ctrl_o (ctrl)
  );

  risc_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .ctrl_i    (ctrl),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .imm_i     (instr_i[15:0]),
    .sa_i      (instr_i[10:6]),
    .result_o  (result_o),
    .ovf_raw_o (ovf_raw)
  );

  risc_exec_wb_gate u_wb (
    .legal_i   (ctrl.legal),
    .traps_i   (ctrl.traps),
    .dst_rd_i  (ctrl.dst_rd),
    .ovf_raw_i (ovf_raw),
    .rd_i      (instr_i[15:11]),
    .rt_i      (instr_i[20:16]),
    .dst_idx_o (dst_idx_o),
    .wr_en_o   (wr_en_o),
    .ovf_o     (ovf_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/risc_exec_chk.sv
module risc_exec_chk
  import risc_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [INSTR_W-1:0]   instr_i,
  input logic [DATA_W-1:0]    rs_val_i,
  input logic [DATA_W-1:0]    rt_val_i,
  input logic [REG_IDX_W-1:0] dst_idx_o,
  input logic                 wr_en_o,
  input logic [DATA_W-1:0]    result_o,
  input logic                 ovf_o,
  input logic                 illegal_o
);
  always_comb begin
    // R3
    if (ovf_o) no_write_on_ovf_chk: assert (!wr_en_o);
    // R10
    if (dst_idx_o == '0) zero_dst_chk: assert (!wr_en_o);
    // R11
    if (illegal_o) illegal_quiet_chk: assert (!wr_en_o && !ovf_o);
    // R1
    if (instr_i[31:26] == 6'd0) reg_dst_chk: assert (dst_idx_o == instr_i[15:11]);
    // R5
    if (instr_i[31:26] == 6'd10 || instr_i[31:26] == 6'd11)
      cmp_bool_chk: assert (result_o[DATA_W-1:1] == '0);
    // R9
    if (instr_i[31:26] == 6'd15) lui_low_chk: assert (result_o[15:0] == 16'h0);
    // R2
    if (instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'h21 && rt_val_i == '0)
      addu_ident_chk: assert (result_o == rs_val_i && !ovf_o);
    // R4
    if (instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'h25 && rs_val_i == '0)
      or_ident_chk: assert (result_o == rt_val_i);
  end
endmodule

bind risc_exec_unit risc_exec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/risc_exec_unit_tb.sv
module risc_exec_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0, a = '0, b = '0;
  logic [4:0]  dst;
  logic        wr, ovf, ill;
  logic [31:0] res;
  int total = 0, bad = 0, cyc = 0;

  typedef struct packed {
    logic wr; logic [4:0] dst; logic [31:0] res; logic ovf; logic ill;
  } exp_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  risc_exec_unit u_dut (
    .instr_i(instr), .rs_val_i(a), .rt_val_i(b),
    .dst_idx_o(dst), .wr_en_o(wr), .result_o(res), .ovf_o(ovf), .illegal_o(ill)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic exp_t model(logic [31:0] i, logic [31:0] x, logic [31:0] y);
    exp_t e;
    logic [5:0] op = i[31:26], fn = i[5:0];
    logic [4:0] sa = i[10:6];
    logic [31:0] se = {{16{i[15]}}, i[15:0]};
    logic [31:0] ze = {16'h0, i[15:0]};
    logic trap = 1'b0, ov = 1'b0;
    e = '0; e.dst = i[20:16];
    if (op == 0) begin
      e.dst = i[15:11];
      case (fn)
        6'h20: begin e.res = x + y; trap = 1; ov = (x[31] == y[31]) && (e.res[31] != x[31]); end
        6'h21: e.res = x + y;
        6'h22: begin e.res = x - y; trap = 1; ov = (x[31] != y[31]) && (e.res[31] != x[31]); end
        6'h23: e.res = x - y;
        6'h24: e.res = x & y;
        6'h25: e.res = x | y;
        6'h26: e.res = x ^ y;
        6'h27: e.res = ~(x | y);
        6'h2A: e.res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        6'h2B: e.res = (x < y) ? 32'd1 : 32'd0;
        6'h00: e.res = y << sa;
        6'h02: e.res = y >> sa;
        6'h03: e.res = 32'($signed(y) >>> sa);
        6'h04: e.res = x << y[4:0];
        6'h06: e.res = x >> y[4:0];
        6'h07: e.res = 32'($signed(x) >>> y[4:0]);
        default: e.ill = 1;
      endcase
    end else begin
      case (op)
        6'd8:  begin e.res = x + se; trap = 1; ov = (x[31] == se[31]) && (e.res[31] != x[31]); end
        6'd9:  e.res = x + se;
        6'd10: e.res = ($signed(x) < $signed(se)) ? 32'd1 : 32'd0;
        6'd11: e.res = (x < se) ? 32'd1 : 32'd0;
        6'd12: e.res = x & ze;
        6'd13: e.res = x | ze;
        6'd14: e.res = x ^ ze;
        6'd15: e.res = {i[15:0], 16'h0};
        default: e.ill = 1;
      endcase
    end
    e.ovf = !e.ill && trap && ov;
    e.wr  = !e.ill && !e.ovf && (e.dst != 0);
    return e;
  endfunction

  function automatic string tag_of(logic [31:0] i);
    if (i[31:26] == 0) begin
      case (i[5:0])
        6'h20, 6'h22: return "R3";
        6'h21, 6'h23: return "R2";
        6'h24, 6'h25, 6'h26, 6'h27: return "R4";
        6'h2A, 6'h2B: return "R5";
        6'h00, 6'h02, 6'h03: return "R7";
        6'h04, 6'h06, 6'h07: return "R8";
        default: return "R11";
      endcase
    end
    case (i[31:26])
      6'd8: return "R3";
      6'd9: return "R2";
      6'd10, 6'd11: return "R5";
      6'd12, 6'd13, 6'd14: return "R6";
      6'd15: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] rfmt(int rs, int rt, int rd, int sa, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sa), fn};
  endfunction
  function automatic logic [31:0] ifmt(logic [5:0] op, int rs, int rt, logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction

  task automatic apply(logic [31:0] i, logic [31:0] x, logic [31:0] y, string tag);
    exp_t e;
    @(posedge clk);
    instr <= i; a <= x; b <= y;
    @(negedge clk);
    e = model(i, x, y);
    total++;
    if (wr !== e.wr || ovf !== e.ovf || ill !== e.ill || (!e.ill && (dst !== e.dst || res !== e.res))) begin
      bad++;
      $display("FAIL %s instr=%h a=%h b=%h: actual wr=%b dst=%0d res=%h ovf=%b ill=%b expected wr=%b dst=%0d res=%h ovf=%b ill=%b",
               tag, i, x, y, wr, dst, res, ovf, ill, e.wr, e.dst, e.res, e.ovf, e.ill);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'h7fffffff;
      2: return 32'h80000000;
      3: return 32'hffffffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [5:0] fns [16] = '{6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h26,6'h27,
                             6'h2A,6'h2B,6'h00,6'h02,6'h03,6'h04,6'h06,6'h07};
    void'($urandom(32'h5eed_1234));
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R10: all-zero word does nothing
    apply(32'h0, 32'h1234, 32'h5678, "R10");
    // R3: trapping add overflow, R2: wrapping add
    apply(rfmt(1, 2, 3, 0, 6'h20), 32'h7fffffff, 32'h1, "R3");
    apply(rfmt(1, 2, 3, 0, 6'h21), 32'h7fffffff, 32'h1, "R2");
    apply(rfmt(1, 2, 3, 0, 6'h22), 32'h80000000, 32'h1, "R3");
    apply(ifmt(6'd8, 1, 4, 16'h0001), 32'h7fffffff, 32'h0, "R3");
    apply(ifmt(6'd9, 1, 4, 16'hffff), 32'h0, 32'h0, "R2");
    // R6: zero-extended logical immediate
    apply(ifmt(6'd13, 0, 8, 16'hffff), 32'h0, 32'h0, "R6");
    // R5: sign-extended then unsigned compare
    apply(ifmt(6'd11, 9, 8, 16'hffff), 32'h5, 32'h0, "R5");
    apply(ifmt(6'd10, 9, 8, 16'hffff), 32'h5, 32'h0, "R5");
    apply(rfmt(9, 10, 8, 0, 6'h2A), 32'hffffffff, 32'h1, "R5");
    apply(rfmt(9, 10, 8, 0, 6'h2B), 32'hffffffff, 32'h1, "R5");
    // R7 / R8: shift fill and ignored upper count bits
    apply(rfmt(0, 9, 8, 1, 6'h03), 32'h0, 32'hfffffff9, "R7");
    apply(rfmt(0, 9, 8, 3, 6'h02), 32'h0, 32'hffffffff, "R7");
    apply(rfmt(9, 10, 8, 0, 6'h06), 32'h00000010, 32'hffffffe1, "R8");
    apply(rfmt(9, 10, 8, 0, 6'h07), 32'h80000000, 32'h0000003f, "R8");
    // R9
    apply(ifmt(6'd15, 0, 8, 16'h1234), 32'hdead, 32'hbeef, "R9");
    // R1: I-format goes to rt, R-format to rd
    apply(ifmt(6'd12, 3, 17, 16'h00ff), 32'h12345678, 32'h0, "R1");
    apply(rfmt(3, 4, 18, 0, 6'h24), 32'hf0f0f0f0, 32'hff00ff00, "R1");
    // R10: zero destination with otherwise valid op
    apply(rfmt(1, 2, 0, 0, 6'h21), 32'h5, 32'h6, "R10");
    // R11
    apply(ifmt(6'd63, 1, 2, 16'h1), 32'h1, 32'h1, "R11");
    apply(rfmt(1, 2, 3, 0, 6'h01), 32'h1, 32'h1, "R11");
    apply(rfmt(1, 2, 3, 0, 6'h20) | 32'h0, 32'h7fffffff, 32'h7fffffff, "R3");
    for (int n = 0; n < N_RAND; n++) begin
      logic [31:0] i;
      int k = $urandom_range(0, 9);
      if (k < 5)
        i = rfmt($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
                 $urandom_range(0, 31), fns[$urandom_range(0, 15)]);
      else if (k < 9)
        i = ifmt(6'($urandom_range(8, 15)), $urandom_range(0, 31), $urandom_range(0, 31),
                 16'($urandom));
      else
        i = $urandom;
      apply(i, pick_val(), pick_val(), tag_of(i));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule